// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single-clock transfer requests from an 8-bit processor core into external bus cycles on a bus where the low address byte and the data byte share one set of lines. Each request is a memory or I/O read, a memory or I/O write, or an opcode fetch. The block steps through fixed T-states, one clock each. It drives the high address byte on its own outputs. In T1 it puts the low address byte on the shared lines with an address strobe, so an external latch can hold the low byte for the rest of the cycle. After T1 it either drives write data on the shared lines or releases them for the addressed device.

The block also gives the bus to an external DMA master on request, and it supplies a reset output for the rest of the system. Pad tristate control is expressed through output enables. `bus_oe_o` covers the high address byte and the strobes. `ad_oe_o` covers the shared byte. A low enable means the pads float.

Top module: `mbus_seq`

## Requirements
- R1: While `rst_ni` is low, `reset_out_o`=1, `ale_o`=0, `rd_no`=`wr_no`=1, `hlda_o`=0, `ad_oe_o`=0 and `bus_oe_o`=1. `reset_out_o` falls at the first rising clock edge after `rst_ni` goes high.
- R2: A one-clock `req_i` strobe is accepted only when the block is idle and `hold_i` is low. A strobe at any other time is dropped and produces no bus cycle.
- R3: In the first clock after acceptance (T1), `ale_o`=1 for exactly that clock. `addr_hi_o` carries address bits 15..8, and `ad_o` drives address bits 7..0 with `ad_oe_o`=1. Both strobes are high. `io_m_o` is 0 for memory and 1 for I/O, and it holds that value from T1 to the end of the cycle.
- R4: A read holds `rd_no` low in T2 and T3, and `ad_oe_o` stays low from T2 onward. The byte on `ad_i` is captured at the rising edge that ends T3.
- R5: A write holds `wr_no` low in T2 only. It drives the write byte on `ad_o` with `ad_oe_o`=1 in T2 and T3, so the data outlives the strobe by one clock. `rd_no` stays high.
- R6: An opcode fetch (`req_fetch_i`=1) is a read with a fourth state T4, during which both strobes are high, `ad_oe_o`=0 and `ale_o`=0. `req_write_i` is ignored for a fetch.
- R7: `done_o` is high for exactly the one clock after T3. When it rises, `rdata_o` shows the byte read. `rdata_o` keeps that value until the next read or fetch completes, and writes leave it unchanged.
- R8: `hold_i` is acted on only while idle, so a started cycle always finishes. One clock after an idle clock with `hold_i`=1, `hlda_o`=1 and `bus_oe_o`=`ad_oe_o`=0. Hold wins over a request strobed in the same clock.
- R9: `hlda_o` falls at the first rising edge at which `hold_i` is sampled low, and the bus outputs are driven again from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one T-state per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-clock transfer request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_fetch_i | input | 1 | 1 = opcode fetch (adds T4) |
| req_addr_i | input | 16 | Transfer address |
| req_wdata_i | input | 8 | Write byte |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Registered read byte |
| addr_hi_o | output | 8 | High address byte |
| ad_o | output | 8 | Shared low address / data out |
| ad_i | input | 8 | Shared low address / data in |
| ad_oe_o | output | 1 | Drive enable for the shared byte |
| bus_oe_o | output | 1 | Drive enable for the high address and the strobes |
| ale_o | output | 1 | Address latch strobe, high in T1 |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| hold_i | input | 1 | DMA bus request |
| hlda_o | output | 1 | DMA bus grant |
| reset_out_o | output | 1 | Reset output for external devices |

## Verification
The checker assumes the core presents `req_i` as a strobe and keeps the request fields stable for that clock. It also assumes `hold_i` changes only between clock edges. The bench drives every input at the falling clock edge and raises each request for exactly one clock. It raises hold in three situations: in the middle of a cycle, in the same clock as a request, and while the bus is idle. This exercises the rule that a granted bus is never torn out of a started transfer.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_T4,
    ST_HOLD
  } tstate_e;

  typedef struct packed {
    logic wr;
    logic io;
    logic fetch;
  } cyc_kind_t;
endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
  import mbus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    hold_i,
  input  logic    fetch_i,
  output tstate_e state_o,
  output logic    start_o
);
  tstate_e state_q, state_d;

  assign start_o = (state_q == ST_IDLE) && !hold_i && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        // hold checked only between cycles
        if (hold_i)     state_d = ST_HOLD;
        else if (req_i) state_d = ST_T1;
      end
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = fetch_i ? ST_T4 : ST_IDLE;
      ST_T4:   state_d = ST_IDLE;
      ST_HOLD: state_d = hold_i ? ST_HOLD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mbus_cap.sv
module mbus_cap
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic              io_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  tstate_e           state_i,
  input  logic [DATA_W-1:0] ad_i,
  output cyc_kind_t         kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  cyc_kind_t         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              done_q;
  logic              t3;

  assign t3 = (state_i == ST_T3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_i) begin
      kind_q.wr    <= write_i & ~fetch_i;
      kind_q.io    <= io_i;
      kind_q.fetch <= fetch_i;
      addr_q       <= addr_i;
      wdata_q      <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= t3;
      if (t3 && !kind_q.wr) rdata_q <= ad_i;
    end
  end

  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
  assign done_o  = done_q;
endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  tstate_e           state_i,
  input  cyc_kind_t         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              bus_oe_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              io_m_o,
  output logic              hlda_o
);
  logic t1, t23;

  assign t1  = (state_i == ST_T1);
  assign t23 = (state_i == ST_T2) || (state_i == ST_T3);

  always_comb begin
    addr_hi_o = addr_i[ADDR_W-1:DATA_W];
    ad_o      = t1 ? addr_i[DATA_W-1:0] : wdata_i;
    ad_oe_o   = t1 || (kind_i.wr && t23);
    bus_oe_o  = (state_i != ST_HOLD);
    ale_o     = t1;
    rd_no     = !(!kind_i.wr && t23);
    // strobe ends one clock before the data is dropped
    wr_no     = !(kind_i.wr && state_i == ST_T2);
    io_m_o    = kind_i.io;
    hlda_o    = (state_i == ST_HOLD);
  end
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic              req_fetch_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ad_oe_o,
  output logic              bus_oe_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              io_m_o,
  input  logic              hold_i,
  output logic              hlda_o,
  output logic              reset_out_o
);
  tstate_e           state;
  logic              start;
  cyc_kind_t         kind;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rst_out_q;

  mbus_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .hold_i  (hold_i),
    .fetch_i (kind.fetch),
    .state_o (state),
    .start_o (start)
  );

  mbus_cap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .write_i (req_write_i),
    .io_i    (req_io_i),
    .fetch_i (req_fetch_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .state_i (state),
    .ad_i    (ad_i),
    .kind_o  (kind),
    .addr_o  (addr_q),
    .wdata_o (wdata_q),
    .rdata_o (rdata_o),
    .done_o  (done_o)
  );

  mbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .state_i   (state),
    .kind_i    (kind),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .addr_hi_o (addr_hi_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .bus_oe_o  (bus_oe_o),
    .ale_o     (ale_o),
    .rd_no     (rd_no),
    .wr_no     (wr_no),
    .io_m_o    (io_m_o),
    .hlda_o    (hlda_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_out_q <= 1'b1;
    else         rst_out_q <= 1'b0;
  end

  assign reset_out_o = rst_out_q;
endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic done_o,
  input logic ad_oe_o,
  input logic bus_oe_o,
  input logic ale_o,
  input logic rd_no,
  input logic wr_no,
  input logic hold_i,
  input logic hlda_o,
  input logic reset_out_o
);
  a_r1_rstout_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> !reset_out_o);

  a_r3_ale_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  a_r3_ale_addr_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (ad_oe_o && rd_no && wr_no));

  a_r4_read_releases_ad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);

  a_r5_data_outlives_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |=> (ad_oe_o && wr_no));

  a_r5_no_strobe_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_no || wr_no);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_hold_floats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!bus_oe_o && !ad_oe_o && !ale_o));

  a_r8_grant_between_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> $past(rd_no && wr_no && !ale_o && !ad_oe_o));

  a_r9_hlda_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlda_o && !hold_i) |=> !hlda_o);
endmodule

bind mbus_seq mbus_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .ad_oe_o     (ad_oe_o),
  .bus_oe_o    (bus_oe_o),
  .ale_o       (ale_o),
  .rd_no       (rd_no),
  .wr_no       (wr_no),
  .hold_i      (hold_i),
  .hlda_o      (hlda_o),
  .reset_out_o (reset_out_o)
);

// File: tb/mbus_seq_tb_top.sv
module mbus_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_write_i = 1'b0, req_io_i = 1'b0, req_fetch_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        done_o;
  logic [7:0]  rdata_o, addr_hi_o, ad_o;
  logic [7:0]  ad_i = '0;
  logic        ad_oe_o, bus_oe_o, ale_o, rd_no, wr_no, io_m_o;
  logic        hold_i = 1'b0;
  logic        hlda_o, reset_out_o;

  int total = 0;
  int bad = 0;
  logic [7:0] lat_lo = '0;

  always #10 clk_i = ~clk_i;

  // external low-address latch model
  always @(negedge clk_i) if (ale_o) lat_lo <= ad_o;

  mbus_seq dut_i (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic issue(logic w, logic io, logic f, logic [15:0] a, logic [7:0] d);
    req_i = 1'b1; req_write_i = w; req_io_i = io; req_fetch_i = f;
    req_addr_i = a; req_wdata_i = d;
    step();
    req_i = 1'b0;
  endtask

  task automatic t1_checks(logic [15:0] a, logic io);
    chk("R3 ale in T1", ale_o, 1);
    chk("R3 addr_hi", addr_hi_o, a[15:8]);
    chk("R3 ad drive", ad_oe_o, 1);
    chk("R3 ad low addr", ad_o, a[7:0]);
    chk("R3 io_m", io_m_o, io);
    chk("R3 strobes idle", {rd_no, wr_no}, 2'b11);
  endtask

  task automatic t_reset();
    step();
    chk("R1 reset_out", reset_out_o, 1);
    chk("R1 ale", ale_o, 0);
    chk("R1 strobes", {rd_no, wr_no}, 2'b11);
    chk("R1 hlda", hlda_o, 0);
    chk("R1 oe", {ad_oe_o, bus_oe_o}, 2'b01);
    rst_ni = 1'b1;
    #1 chk("R1 reset_out before edge", reset_out_o, 1);
    step();
    chk("R1 reset_out cleared", reset_out_o, 0);
  endtask

  task automatic t_read(logic [15:0] a, logic [7:0] d, logic io);
    issue(0, io, 0, a, 8'h00);
    t1_checks(a, io);
    step();
    chk("R3 latched low addr", lat_lo, a[7:0]);
    chk("R3 ale one clock", ale_o, 0);
    chk("R4 rd low T2", rd_no, 0);
    chk("R4 ad released T2", ad_oe_o, 0);
    chk("R3 io_m held", io_m_o, io);
    ad_i = d;
    step();
    chk("R4 rd low T3", rd_no, 0);
    chk("R7 no done yet", done_o, 0);
    step();
    ad_i = 8'h00;
    chk("R7 done", done_o, 1);
    chk("R7 rdata", rdata_o, d);
    chk("R4 rd high", rd_no, 1);
    step();
    chk("R7 done one clock", done_o, 0);
    chk("R7 rdata kept", rdata_o, d);
  endtask

  task automatic t_write(logic [15:0] a, logic [7:0] d, logic io, logic [7:0] prev);
    issue(1, io, 0, a, d);
    t1_checks(a, io);
    step();
    chk("R5 wr low T2", wr_no, 0);
    chk("R5 rd high", rd_no, 1);
    chk("R5 data T2", {ad_oe_o, ad_o}, {1'b1, d});
    step();
    chk("R5 wr high T3", wr_no, 1);
    chk("R5 data held T3", {ad_oe_o, ad_o}, {1'b1, d});
    step();
    chk("R5 ad released", ad_oe_o, 0);
    chk("R7 done write", done_o, 1);
    chk("R7 rdata untouched", rdata_o, prev);
  endtask

  task automatic t_fetch(logic [15:0] a, logic [7:0] d);
    issue(1, 0, 1, a, 8'hEE); // R6: write flag ignored
    t1_checks(a, 0);
    step();
    chk("R6 fetch reads", {rd_no, wr_no}, 2'b01);
    ad_i = d;
    step();
    chk("R6 rd T3", rd_no, 0);
    step();
    ad_i = 8'h00;
    chk("R6 T4 strobes", {rd_no, wr_no}, 2'b11);
    chk("R6 T4 ad off", {ad_oe_o, ale_o}, 2'b00);
    chk("R7 done in T4", done_o, 1);
    chk("R7 fetched byte", rdata_o, d);
    issue(0, 0, 0, 16'h1234, 8'h00); // R2: strobe during T4 dropped
    chk("R2 no T1 after busy req", ale_o, 0);
    step();
    chk("R2 still idle", ale_o, 0);
  endtask

  task automatic t_ignore_busy();
    issue(0, 0, 0, 16'h4000, 8'h00);
    step();
    issue(1, 1, 0, 16'hBEEF, 8'h55); // strobe in T2
    chk("R2 busy req no write", wr_no, 1);
    step();
    chk("R2 no new ale", ale_o, 0);
    step();
    chk("R2 no new ale later", {ale_o, ad_oe_o}, 2'b00);
  endtask

  task automatic t_hold_mid();
    issue(0, 0, 0, 16'h8081, 8'h00);
    hold_i = 1'b1;
    step();
    chk("R8 no grant mid cycle", {hlda_o, bus_oe_o, rd_no}, 3'b010);
    step();
    chk("R8 no grant T3", hlda_o, 0);
    step();
    chk("R8 cycle completed", done_o, 1);
    chk("R8 grant not yet", hlda_o, 0);
    step();
    chk("R8 granted", hlda_o, 1);
    chk("R8 pins float", {bus_oe_o, ad_oe_o}, 2'b00);
    issue(0, 0, 0, 16'h2222, 8'h00); // R2: strobe during hold dropped
    chk("R8 still granted", hlda_o, 1);
    hold_i = 1'b0;
    #1 chk("R9 hlda until edge", hlda_o, 1);
    step();
    chk("R9 hlda dropped", hlda_o, 0);
    chk("R9 bus driven", bus_oe_o, 1);
    chk("R2 req in hold lost", ale_o, 0);
  endtask

  task automatic t_hold_priority();
    hold_i = 1'b1;
    issue(0, 0, 0, 16'h3333, 8'h00);
    chk("R8 hold beats req", {hlda_o, ale_o}, 2'b10);
    step();
    hold_i = 1'b0;
    step();
    chk("R9 released", hlda_o, 0);
    chk("R8 req lost", ale_o, 0);
  endtask

  initial begin
    t_reset();
    t_read(16'h2005, 8'h4F, 0);
    t_read(16'h00C3, 8'hA5, 1);
    t_write(16'h7F10, 8'h3C, 0, 8'hA5);
    t_write(16'h00A7, 8'hC3, 1, 8'hA5);
    t_fetch(16'hFFFF, 8'h96);
    t_ignore_busy();
    t_hold_mid();
    t_hold_priority();
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule